// File: doc/BRIEF.md
# Audio Sample Buffer FIFO

This block is an eight-word, 32-bit first-in first-out buffer meant to sit between an audio serial port and the system side of a chip. One build parameter chooses its direction. The transmit build raises its threshold flag when the buffer runs low, so the producer knows to refill it. The receive build raises the flag when the buffer has filled far enough to be worth draining.

The head word is always visible on the read data port. A pop advances past it. The fill level is reported as a count, together with full and empty indications. Pushing into a full buffer and popping from an empty one each set their own sticky error flag, and each flag is cleared only by a write-one-to-clear input.

A one-cycle flush returns both pointers to the first slot, so the buffer reads as empty. It does not touch the stored words or the error flags. When DMA service is enabled, a request output tells a DMA engine that it may move a word. The transmit build requests while there is room, and the receive build requests while there is data.

Top module: `audio_buf_fifo`

## Requirements
- R1: While reset is held and right after it, level is 0, empty is 1, full is 0, both error flags are 0 and pop_data is 0.
- R2: Words leave in the order they were pushed. pop_data shows the oldest stored word, and each accepted push or pop moves the level up or down by one in the following cycle.
- R3: full is 1 exactly when the level is 8, and empty is 1 exactly when the level is 0.
- R4: A push while full without a pop in the same cycle is dropped. It sets the overflow flag, and the level and head word stay unchanged.
- R5: A pop while empty sets the underflow flag, leaves the level at 0 and does not advance the read position. pop_data reads 0 while the buffer is empty.
- R6: Each error flag stays 1 until its clear input is pulsed. If a new error arrives in the same cycle as the clear pulse, the flag stays 1.
- R7: In the transmit build, thresh_hit is 1 exactly when the level is at or below the 3-bit thresh input.
- R8: In the receive build, thresh_hit is 1 exactly when the level is at or above thresh.
- R9: A flush pulse empties the buffer in the next cycle and restarts both positions at the first slot. Any push or pop in the same cycle is ignored, and the error flags keep their values.
- R10: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the level unchanged. A push together with a pop on a full buffer is accepted.
- R11: dma_req is 0 while dma_en is 0. With dma_en at 1, the transmit build requests while not full and the receive build requests while not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Store push_data this cycle |
| push_data | input | 32 | Word to store |
| pop | input | 1 | Discard the head word this cycle |
| pop_data | output | 32 | Head word, 0 when empty |
| flush | input | 1 | One-cycle pointer restart |
| thresh | input | 3 | Threshold level |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| udf_clr | input | 1 | Write-one-to-clear for the underflow flag |
| dma_en | input | 1 | Enables the DMA request |
| level | output | 4 | Number of stored words |
| full | output | 1 | Level equals 8 |
| empty | output | 1 | Level equals 0 |
| thresh_hit | output | 1 | Threshold condition for the built direction |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |
| dma_req | output | 1 | DMA service request |

## Verification
The bench drives a transmit build and a receive build with the same stimulus. The two thresholds must then disagree whenever the level sits strictly between threshold values. A comparison with its direction swapped, or one written as strict instead of inclusive, shows up at once.

The corner cases are these. A pop on an empty buffer must not move the read position, or the next pushed word would be skipped. A push into a full buffer must not overwrite the head. A push and a pop together on a full buffer must still be accepted, or the level would drop. A flush must leave the sticky flags alone, and a clear pulse that coincides with a fresh error must lose to that error. A design that got one of these wrong would show a wrong head word, a wrong level, or a flag that vanishes early.

// File: rtl/afb_pkg.sv
// Shared types for the audio sample buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package afb_pkg;
    // Direction selects threshold sense and DMA request condition.
    typedef enum logic {
        AFB_TX = 1'b0,
        AFB_RX = 1'b1
    } afb_dir_e;
endpackage

// File: rtl/afb_ctrl.sv
// Pointer and level control for the sample buffer.
// Decides which pushes and pops are accepted, tracks read and write slots and
// the fill level, and reports overflow and underflow events for one cycle.
// Assumes: flush has priority over push and pop; a pop frees room for a push
// in the same cycle.
module afb_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovf_evt,
    output logic          udf_evt
);
    logic pop_ok;
    logic push_ok;

    // Occupancy decodes from the registered level.
    always_comb begin
        full  = (level == CW'(DEPTH));
        empty = (level == '0);
    end

    // Acceptance and error events for this cycle.
    always_comb begin
        pop_ok  = pop && !empty && !flush;
        push_ok = push && !flush && (!full || pop_ok);
        ovf_evt = push && !flush && full && !pop_ok;
        udf_evt = pop && !flush && empty;
        wr_en   = push_ok;
    end

    // Pointer and level state, restarted by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
        end else begin
            if (push_ok)
                wr_idx <= (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            if (pop_ok)
                rd_idx <= (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            if (push_ok && !pop_ok)
                level <= level + 1'b1;
            else if (pop_ok && !push_ok)
                level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/afb_store.sv
// Word storage for the sample buffer: one write port, one asynchronous read.
// Assumes: indices are always in range; contents are zeroed only by reset.
module afb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slots [DEPTH];

    // Store the accepted word; reset zeroes every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    // Present the word at the read slot.
    always_comb rd_data = slots[rd_idx];
endmodule

// File: rtl/afb_flags.sv
// Sticky error flags, threshold compare and DMA request for the buffer.
// The direction parameter picks the low-water or high-water threshold and the
// matching request condition.
// Assumes: thresh is no wider than the level.
module afb_flags
    import afb_pkg::*;
#(
    parameter afb_dir_e DIR  = AFB_TX,
    parameter int       CW   = 4,
    parameter int       TW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovf_evt,
    input  logic          udf_evt,
    input  logic          ovf_clr,
    input  logic          udf_clr,
    input  logic [CW-1:0] level,
    input  logic          full,
    input  logic          empty,
    input  logic [TW-1:0] thresh,
    input  logic          dma_en,
    output logic          ovf_flag,
    output logic          udf_flag,
    output logic          thresh_hit,
    output logic          dma_req
);
    logic [CW-1:0] th_ext;

    // Widen the threshold to the level width.
    always_comb th_ext = CW'(thresh);

    // Sticky flags: a new event outranks a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt || (ovf_flag && !ovf_clr);
            udf_flag <= udf_evt || (udf_flag && !udf_clr);
        end
    end

    generate
        if (DIR == AFB_TX) begin : g_tx
            // Low-water mark; request while room remains.
            always_comb begin
                thresh_hit = (level <= th_ext);
                dma_req    = dma_en && !full;
            end
        end else begin : g_rx
            // High-water mark; request while data remains.
            always_comb begin
                thresh_hit = (level >= th_ext);
                dma_req    = dma_en && !empty;
            end
        end
    endgenerate
endmodule

// File: rtl/audio_buf_fifo.sv
// Audio sample buffer: fixed-depth FIFO with flush, fill level, directional
// threshold, sticky error flags and DMA request.
// Assumes: synchronous active-low reset; pop_data is the head word and reads
// zero while the buffer is empty.
module audio_buf_fifo
    import afb_pkg::*;
#(
    parameter int       DW    = 32,
    parameter int       DEPTH = 8,
    parameter afb_dir_e DIR   = AFB_TX,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    input  logic          flush,
    input  logic [AW-1:0] thresh,
    input  logic          ovf_clr,
    input  logic          udf_clr,
    input  logic          dma_en,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          thresh_hit,
    output logic          ovf_flag,
    output logic          udf_flag,
    output logic          dma_req
);
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic          ovf_evt;
    logic          udf_evt;

    afb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .level(level),
        .full(full), .empty(empty), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
    );

    afb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(push_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    afb_flags #(.DIR(DIR), .CW(CW), .TW(AW)) u_flags (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .udf_evt(udf_evt),
        .ovf_clr(ovf_clr), .udf_clr(udf_clr), .level(level), .full(full),
        .empty(empty), .thresh(thresh), .dma_en(dma_en),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag),
        .thresh_hit(thresh_hit), .dma_req(dma_req)
    );

    // Mask the head word while nothing is stored.
    always_comb pop_data = empty ? '0 : rd_data;
endmodule

// File: rtl/afb_checker.sv
// Protocol checks for the audio sample buffer, bound to every instance.
// Assumes: checks are disabled while reset is asserted.
module afb_checker #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          pop,
    input logic          flush,
    input logic          ovf_clr,
    input logic          udf_clr,
    input logic          dma_en,
    input logic [DW-1:0] pop_data,
    input logic [CW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          ovf_flag,
    input logic          udf_flag,
    input logic          dma_req
);
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH) && !(full && empty));

    p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !flush && full |=> ovf_flag && full && $stable(pop_data));

    p_empty_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> pop_data == '0);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    p_udf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag && !udf_clr |=> udf_flag);

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && level == '0);

    p_flush_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !ovf_clr && !udf_clr |=> $stable(ovf_flag) && $stable(udf_flag));

    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !flush && !empty |=> $stable(level));

    p_dma_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dma_en);
endmodule

bind audio_buf_fifo afb_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .ovf_clr(ovf_clr), .udf_clr(udf_clr), .dma_en(dma_en),
    .pop_data(pop_data), .level(level), .full(full), .empty(empty),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .dma_req(dma_req)
);

// File: tb/tb_audio_buf_fifo.sv
// Bench for the audio sample buffer: a transmit build (dut) and a receive
// build (dut_rx) share all inputs; a vector table runs first, then directed
// corner cases.
module tb_audio_buf_fifo;
    import afb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop = 1'b0;
    logic        flush = 1'b0;
    logic [2:0]  thresh = '0;
    logic        ovf_clr = 1'b0;
    logic        udf_clr = 1'b0;
    logic        dma_en = 1'b0;

    logic [31:0] tx_pop_data, rx_pop_data;
    logic [3:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, tx_th, tx_ovf, tx_udf, tx_dma;
    logic        rx_full, rx_empty, rx_th, rx_ovf, rx_udf, rx_dma;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    audio_buf_fifo #(.DIR(AFB_TX)) dut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(tx_pop_data), .flush(flush), .thresh(thresh),
        .ovf_clr(ovf_clr), .udf_clr(udf_clr), .dma_en(dma_en),
        .level(tx_level), .full(tx_full), .empty(tx_empty),
        .thresh_hit(tx_th), .ovf_flag(tx_ovf), .udf_flag(tx_udf),
        .dma_req(tx_dma)
    );

    audio_buf_fifo #(.DIR(AFB_RX)) dut_rx (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(rx_pop_data), .flush(flush), .thresh(thresh),
        .ovf_clr(ovf_clr), .udf_clr(udf_clr), .dma_en(dma_en),
        .level(rx_level), .full(rx_full), .empty(rx_empty),
        .thresh_hit(rx_th), .ovf_flag(rx_ovf), .udf_flag(rx_udf),
        .dma_req(rx_dma)
    );

    // Vector: {push, pop, thresh[2:0], data[31:0], exp_level[3:0], exp_tx_th, exp_rx_th}
    localparam int VW = 43;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 32'h0000_00A1, 4'd1, 1'b0, 1'b1},
        {1'b1, 1'b0, 3'd2, 32'h0000_00A2, 4'd2, 1'b1, 1'b1},
        {1'b1, 1'b0, 3'd2, 32'h0000_00A3, 4'd3, 1'b0, 1'b1},
        {1'b1, 1'b1, 3'd3, 32'h0000_00A4, 4'd3, 1'b1, 1'b1},
        {1'b0, 1'b1, 3'd4, 32'h0000_0000, 4'd2, 1'b1, 1'b0},
        {1'b1, 1'b0, 3'd1, 32'h0000_00A5, 4'd3, 1'b0, 1'b1},
        {1'b1, 1'b0, 3'd7, 32'h0000_00A6, 4'd4, 1'b1, 1'b0},
        {1'b0, 1'b1, 3'd3, 32'h0000_0000, 4'd3, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; inputs are taken at the next rising edge and
    // results are sampled at the falling edge after it.
    task automatic step(input logic pu, input logic po, input logic fl,
                        input logic oc, input logic uc, input logic [31:0] d);
        push = pu; pop = po; flush = fl; ovf_clr = oc; udf_clr = uc; push_data = d;
        @(negedge clk);
        push = 1'b0; pop = 1'b0; flush = 1'b0; ovf_clr = 1'b0; udf_clr = 1'b0;
        push_data = '0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 level in reset", 32'(tx_level), 32'd0);
        chk("R1 empty in reset", 32'(tx_empty), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 full after reset", 32'(tx_full), 32'd0);
        chk("R1 flags after reset", {30'd0, tx_ovf, tx_udf}, 32'd0);
        chk("R1 pop_data after reset", tx_pop_data, 32'd0);

        // R2 R7 R8 R10: table walk
        for (int i = 0; i < NV; i++) begin
            thresh = VEC[i][40:38];
            step(VEC[i][42], VEC[i][41], 1'b0, 1'b0, 1'b0, VEC[i][37:6]);
            chk($sformatf("R2/R10 level vec %0d", i), 32'(tx_level), 32'(VEC[i][5:2]));
            chk($sformatf("R7 tx thresh vec %0d", i), 32'(tx_th), 32'(VEC[i][1]));
            chk($sformatf("R8 rx thresh vec %0d", i), 32'(rx_th), 32'(VEC[i][0]));
        end

        // R2: order of remaining words A4, A5, A6
        chk("R2 head A4", tx_pop_data, 32'hA4);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R2 head A5", tx_pop_data, 32'hA5);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R2 head A6", rx_pop_data, 32'hA6);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R3 empty at zero", 32'(tx_empty), 32'd1);

        // R5: pop while empty
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R5 underflow set", 32'(tx_udf), 32'd1);
        chk("R5 level stays 0", 32'(tx_level), 32'd0);
        chk("R5 data zero when empty", tx_pop_data, 32'd0);
        // R6: sticky, event beats clear, then clear
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 underflow sticky", 32'(tx_udf), 32'd1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0);
        chk("R6 event beats clear", 32'(tx_udf), 32'd1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        chk("R6 underflow cleared", 32'(tx_udf), 32'd0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hB0);
        chk("R5 read position unmoved", tx_pop_data, 32'hB0);

        // R3 R11: fill to full
        dma_en = 1'b1;
        for (int i = 1; i < 8; i++)
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hB0 + 32'(i));
        chk("R3 level 8", 32'(tx_level), 32'd8);
        chk("R3 full at 8", 32'(tx_full), 32'd1);
        chk("R11 tx no request when full", 32'(tx_dma), 32'd0);
        chk("R11 rx request when not empty", 32'(rx_dma), 32'd1);

        // R4: push while full is dropped
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hC9);
        chk("R4 overflow set", 32'(tx_ovf), 32'd1);
        chk("R4 level unchanged", 32'(tx_level), 32'd8);
        chk("R4 head unchanged", tx_pop_data, 32'hB0);
        // R10: push with pop on full is accepted
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hCA);
        chk("R10 level stays 8", 32'(tx_level), 32'd8);
        chk("R10 head advanced", tx_pop_data, 32'hB1);

        // R9: flush with a same-cycle push
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hEE);
        chk("R9 level 0 after flush", 32'(tx_level), 32'd0);
        chk("R9 empty after flush", 32'(rx_empty), 32'd1);
        chk("R9 overflow kept", 32'(tx_ovf), 32'd1);
        chk("R11 tx request when not full", 32'(tx_dma), 32'd1);
        chk("R11 rx no request when empty", 32'(rx_dma), 32'd0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hD0);
        chk("R9 restart head", tx_pop_data, 32'hD0);
        chk("R9 level 1", 32'(tx_level), 32'd1);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R6 overflow cleared", 32'(tx_ovf), 32'd0);
        dma_en = 1'b0;
        @(negedge clk);
        chk("R11 gated off", {30'd0, tx_dma, rx_dma}, 32'd0);

        summary();
    end
endmodule